// File: doc/BRIEF.md
# Clause-22 MDIO Management Master

This block reads and writes 16-bit PHY management registers over the two-wire management interface. A host raises a one-cycle start strobe together with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. The block then sends one complete serial frame and raises a one-cycle done pulse. For a read, the assembled word appears on the read data output in that same cycle.

The management clock MDC is made by dividing the system clock. Each MDC half-period lasts `HALF_DIV` system clocks, and MDC stays low whenever no frame is in progress. The serial data line is presented as three signals for an external tri-state pad: an output value, an output enable and an input value. The master changes its output value only while MDC is low. It samples the input in the system clock cycle that ends the low half of each bit.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no frame is in progress, `mdc` is 0, `mdio_oe` is 0 and `busy` is 0.
- R2: Every frame opens with 32 bits of value 1 on `mdio_o`. Each bit is carried by one full MDC period, low half first, with `mdio_oe` at 1.
- R3: After the preamble, a 16-bit header is sent MSB first with `mdio_oe` at 1. Header bits 15:14 are the start pattern 01. Bits 13:12 are the opcode: 10 for a read, 01 for a write. Bits 11:7 carry the PHY address and bits 6:2 carry the register address.
- R4: On a write, header bits 1:0 are the turnaround value 10. They are followed by the 16 write data bits, MSB first. `mdio_oe` stays 1 through the last data bit.
- R5: On a read, `mdio_oe` drops to 0 before the first turnaround bit period. It stays 0 for both turnaround bits and all 16 data bit periods.
- R6: On a read, the 16 data bits are sampled from `mdio_i` MSB first during the low half of each data bit. The assembled word is on `rd_data` when `done` is 1.
- R7: Every MDC high half and low half lasts exactly `HALF_DIV` system clocks. `mdio_o` never changes while `mdc` is high.
- R8: `busy` is 1 from the cycle after a start until the last MDC falling edge. In the cycle after that edge, `done` is 1 for exactly one cycle and `busy` is 0.
- R9: A start strobe that arrives while `busy` is 1 is ignored. The frame in progress continues unchanged and only one `done` pulse follows.
- R10: After the 64th bit, `mdc` returns to 0 and stays at 0 until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a frame |
| rd_nwr | input | 1 | 1 selects a read, 0 a write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for a write |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Word captured by the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data value toward the pad |
| mdio_oe | output | 1 | Pad output enable |
| mdio_i | input | 1 | Serial data value from the pad |

## Verification
The hardest timing to reach from the ports is the read data phase. The bench has to present each data bit on `mdio_i` after one MDC rising edge and before the system clock edge that closes the next low half. It also has to confirm that the output driver was already released when the turnaround bits began. A bench-side PHY model handles this by counting MDC rising edges and driving the next read bit right after each rise. It also records `mdio_o` and `mdio_oe` at every rise, so the whole frame and the enable profile can be compared against values built arithmetically. A second start, with different inputs, is injected in the middle of selected frames to show that it is ignored.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = 16;
    localparam int DAT_BITS   = 16;
    localparam int FRAME_BITS = PRE_BITS + HDR_BITS + DAT_BITS;
    localparam int TA_IDX     = PRE_BITS + HDR_BITS - 2;
    localparam int DAT_IDX    = PRE_BITS + HDR_BITS;

    typedef enum logic [1:0] {
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10
    } mdio_opc_e;

    typedef struct packed {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
    } mdio_req_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(mdio_req_t r);
        logic [HDR_BITS-1:0] hdr;
        mdio_opc_e           opc;
        logic [1:0]          ta;
        logic [DAT_BITS-1:0] dat;
        opc = r.rd ? OPC_READ : OPC_WRITE;
        ta  = r.rd ? 2'b00 : 2'b10;
        dat = r.rd ? '0 : r.wdata;
        hdr = {2'b01, opc, r.phy, r.regad, ta};
        return {{PRE_BITS{1'b1}}, hdr, dat};
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int HALF_DIV = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

    generate
        if (HALF_DIV > 1) begin : g_spacing
            a_r7_tick_spacing: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick)
                else $error("a_r7_tick_spacing");
        end
    endgenerate

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  mdio_req_t   req,
    input  logic        tick,
    input  logic        mdi,
    output logic        run,
    output logic        mdc,
    output logic        mdo,
    output logic        mdo_oe,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data
);
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] PRE_TA_IDX = IDX_W'(TA_IDX - 1);
    localparam logic [IDX_W-1:0] FIRST_DAT  = IDX_W'(DAT_IDX);

    logic [FRAME_BITS-1:0] frame_q;
    logic [IDX_W-1:0]      bit_idx_q;
    logic                  busy_q, done_q, mdc_q, oe_q, rd_q;
    logic [DAT_BITS-1:0]   rx_q, rd_data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q   <= '0;
            bit_idx_q <= '0;
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            mdc_q     <= 1'b0;
            oe_q      <= 1'b0;
            rd_q      <= 1'b0;
            rx_q      <= '0;
            rd_data_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q    <= 1'b1;
                    frame_q   <= build_frame(req);
                    rd_q      <= req.rd;
                    bit_idx_q <= '0;
                    mdc_q     <= 1'b0;
                    oe_q      <= 1'b1;
                end
            end else if (tick) begin
                if (!mdc_q) begin
                    // end of low half: sample, then raise the clock
                    mdc_q <= 1'b1;
                    if (rd_q && bit_idx_q >= FIRST_DAT) begin
                        rx_q <= {rx_q[DAT_BITS-2:0], mdi};
                    end
                end else begin
                    mdc_q <= 1'b0;
                    if (bit_idx_q == LAST_IDX) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                        oe_q   <= 1'b0;
                        if (rd_q) begin
                            rd_data_q <= rx_q;
                        end
                    end else begin
                        bit_idx_q <= bit_idx_q + 1'b1;
                        frame_q   <= {frame_q[FRAME_BITS-2:0], 1'b0};
                        if (rd_q && bit_idx_q == PRE_TA_IDX) begin
                            oe_q <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    assign run     = busy_q;
    assign mdc     = mdc_q;
    assign mdo     = frame_q[FRAME_BITS-1];
    assign mdo_oe  = oe_q;
    assign busy    = busy_q;
    assign done    = done_q;
    assign rd_data = rd_data_q;

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> (!mdc_q && !oe_q))
        else $error("a_r1_idle_quiet");

    a_r7_mdo_low_only: assert property (@(posedge clk) disable iff (rst)
        (mdc_q && $past(mdc_q)) |-> $stable(frame_q[FRAME_BITS-1]))
        else $error("a_r7_mdo_low_only");

    a_r5_read_released: assert property (@(posedge clk) disable iff (rst)
        (busy_q && rd_q && bit_idx_q >= IDX_W'(TA_IDX)) |-> !oe_q)
        else $error("a_r5_read_released");

    a_r8_done_closes: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!busy_q && !mdc_q && $past(busy_q)))
        else $error("a_r8_done_closes");

    a_r9_request_held: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> $stable(rd_q))
        else $error("a_r9_request_held");

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 50
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        rd_nwr,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mdio_req_t req;
    logic      run, tick;

    assign req = '{rd: rd_nwr, phy: phy_addr, regad: reg_addr, wdata: wr_data};

    mdio_clk_div #(.HALF_DIV(HALF_DIV)) div_i (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    mdio_frame_seq seq_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .req     (req),
        .tick    (tick),
        .mdi     (mdio_i),
        .run     (run),
        .mdc     (mdc),
        .mdo     (mdio_o),
        .mdo_oe  (mdio_oe),
        .busy    (busy),
        .done    (done),
        .rd_data (rd_data)
    );

endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;
    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        rd_nwr = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic        mdio_i = 1'b1;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mdio_master #(.HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst(rst), .start(start), .rd_nwr(rd_nwr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, input logic [15:0] pd, input bit poke);
        logic [63:0] exp_f, got_f, got_oe, exp_oe;
        int rises, seg, bad_half, chg_hi, busy_drop, cyc, dones, poke_state;
        logic pm, pmdo;
        bit done_at_fall, idle_ok;
        exp_f  = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra,
                  (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : wd)};
        exp_oe = rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : 64'hFFFF_FFFF_FFFF_FFFF;
        got_f = '0; got_oe = '0;
        rises = 0; seg = 0; bad_half = 0; chg_hi = 0; busy_drop = 0;
        cyc = 0; dones = 0; poke_state = 0; done_at_fall = 0;
        @(negedge clk);
        rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; start = 1'b1;
        pm = 1'b0; pmdo = mdio_o;
        while (cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin
                start = 1'b0;
                pmdo = mdio_o;
            end
            if (poke && poke_state == 1) begin
                start = 1'b0; rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
                poke_state = 2;
            end
            if (poke && poke_state == 0 && rises == 10) begin
                start = 1'b1; rd_nwr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd;
                poke_state = 1;
            end
            if (mdc && !pm) begin
                if (rises < 64) begin
                    got_f[63-rises]  = mdio_o;
                    got_oe[63-rises] = mdio_oe;
                end
                if (rd && rises >= 47 && rises < 63) mdio_i = pd[15-(rises-47)];
                rises++;
            end
            if (mdc == pm) seg++;
            else begin
                if (seg != HALF) bad_half++;
                seg = 1;
            end
            if (mdc && pm && mdio_o != pmdo) chg_hi++;
            if (done) begin
                dones++;
                done_at_fall = pm && !mdc && !busy;
                break;
            end
            if (!busy) busy_drop++;
            pm = mdc; pmdo = mdio_o;
        end
        mdio_i = 1'b1;
        chk(done_at_fall, "R8 done with busy low after last fall", 64'(done_at_fall), 64'd1);
        chk(busy_drop == 0, "R8 busy held through frame", 64'(busy_drop), 64'd0);
        chk(rises == 64, "R7 MDC period count", 64'(rises), 64'd64);
        chk(bad_half == 0 && chg_hi == 0, "R7 half period and mdo only while low",
            64'(bad_half * 1000 + chg_hi), 64'd0);
        chk(got_f[63:32] == 32'hFFFF_FFFF, "R2 preamble", {32'h0, got_f[63:32]}, 64'hFFFF_FFFF);
        chk(got_oe[63:18] == exp_oe[63:18], "R2 R3 enable during preamble and header",
            {18'h0, got_oe[63:18]}, {18'h0, exp_oe[63:18]});
        chk(got_f[31:18] == exp_f[31:18], poke ? "R9 frame unchanged by extra start" : "R3 header",
            {50'h0, got_f[31:18]}, {50'h0, exp_f[31:18]});
        if (rd) begin
            chk(got_oe[17:0] == 18'h0, "R5 released for turnaround and data",
                {46'h0, got_oe[17:0]}, 64'h0);
            chk(rd_data == pd, "R6 read data", {48'h0, rd_data}, {48'h0, pd});
        end else begin
            chk(got_f[17:0] == exp_f[17:0] && got_oe[17:0] == 18'h3FFFF,
                "R4 write turnaround, data and enable",
                {got_oe[17:0], 28'h0, got_f[17:0]}, {18'h3FFFF, 28'h0, exp_f[17:0]});
        end
        idle_ok = 1;
        for (int k = 0; k < 4 * HALF + 2; k++) begin
            @(negedge clk);
            if (done) dones++;
            if (mdc || mdio_oe || busy) idle_ok = 0;
        end
        chk(idle_ok, "R10 R1 mdc low and idle after frame", 64'(idle_ok), 64'd1);
        chk(dones == 1, poke ? "R9 single done" : "R8 single done pulse", 64'(dones), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!mdc && !mdio_oe && !busy && !done, "R1 reset state",
            {60'h0, mdc, mdio_oe, busy, done}, 64'h0);
        for (int i = 0; i < 32; i++) begin
            logic [15:0] pd, wd;
            pd = (i == 0) ? 16'h0000 : (i == 31) ? 16'hFFFF : (i == 1) ? 16'hAAAA :
                 (16'(i * 16'h1357) ^ 16'hC3A5);
            wd = (i == 0) ? 16'hFFFF : (i == 31) ? 16'h0000 : (i == 1) ? 16'h5555 :
                 (16'(i * 16'h2B1D) ^ 16'h3C5A);
            txn(1'b1, 5'(i), 5'(31 - i), 16'hDEAD, pd, i == 5 || i == 20);
            txn(1'b0, 5'(i), 5'(i) ^ 5'h0A, wd, 16'h0000, i == 9 || i == 27);
        end
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            vectors++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule